// File: doc/BRIEF.md
# Battery Charge Cycle Sequencer

This block steps a backup battery through one charge cycle: precharge, bulk and top-off. When the cycle ends cleanly, it waits until the cell sags enough to need another cycle. All of its inputs are already-qualified single-bit flags from analog comparators and from a host register bank:

- supply present and above lockout
- cell below the recharge point
- cell overvoltage
- a 2-bit thermistor range
- shutdown, power-on-reset command and host charge inhibit

The block drives four outputs:

- a charge-current enable
- a converter run signal
- a 2-bit phase code
- a fault flag

It also exposes the charge timer count, so the host side can follow charge progress.

Each condition has its own handling:

- **Overvoltage** stops only the converter. The current request stays high and the timer keeps counting.
- **A hot battery** removes the current and flags a fault. The timer freezes until the reading returns to range.
- **An open thermistor** means the battery has been removed. It behaves like shutdown and sends the sequencer to idle with the timer cleared.
- **The host inhibit** stops current without freezing the timer.
- **The timer limit** is a parameter. Reaching it before top-off latches a fault. Reaching it during top-off simply ends the cycle.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While and after the synchronous active-high reset, phase is 00, the current enable, converter run and fault are low, and the timer reads 0.
- R2: From idle (or the done state) the sequencer enters precharge (phase 01, timer 0) at the next clock edge when all of these hold: supply present, above lockout, cell below recharge point, no charge inhibit, and a thermistor code of cold (00) or ideal (01) or temperature checking disabled. Otherwise phase stays 00.
- R3: Phase codes are 00 off, 01 precharge, 10 bulk, 11 top-off. The precharge-crossed pulse moves 01 to 10, the bulk-crossed pulse moves 10 to 11, and the top-off-complete pulse moves 11 to 00, each at the next edge.
- R4: After a cycle ends without fault, phase stays 00 with no fault until the cell-below-recharge flag rises. The next edge then starts a new precharge.
- R5: While overvoltage is flagged in an active phase, the converter run is low in the same cycle, the current enable stays high, the timer keeps counting and no fault is raised. The converter run returns when the flag clears.
- R6: While temperature checking is enabled and the thermistor reads hot (10) in an active phase, the current enable and converter run are low and the fault is high in the same cycle, and the timer holds its value. When the reading returns to range, the fault clears and the current and timer resume.
- R7: Supply absent, below lockout, shutdown, power-on-reset command, or (with temperature checking enabled) an open thermistor (11) drops the current enable at once. At the next edge phase becomes 00, the timer becomes 0 and any fault clears.
- R8: While the host inhibit is set in an active phase, the current enable and converter run are low, the phase is held and the timer keeps counting. Clearing it restores the current enable.
- R9: When the timer equals T_LIMIT in precharge or bulk, the next edge latches the fault with phase 00 and current off until an R7 condition clears it. A new cycle cannot start in that state. When the timer equals T_LIMIT in top-off, the cycle ends without fault.
- R10: With temperature checking disabled, the hot and open thermistor codes have no effect on phase, current enable or fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Input supply present |
| above_uvlo | input | 1 | Supply above lockout threshold |
| below_rechg | input | 1 | Cell below auto-recharge point |
| bat_ov | input | 1 | Cell overvoltage (clears at hysteresis) |
| therm_code | input | 2 | Thermistor range: 00 cold, 01 ideal, 10 hot, 11 open |
| temp_chk_en | input | 1 | Enable thermistor qualification |
| shutdown | input | 1 | Shutdown request |
| por_cmd | input | 1 | Host power-on-reset command |
| inhibit | input | 1 | Host charge inhibit |
| pre_done | input | 1 | Precharge current threshold crossed |
| bulk_done | input | 1 | Bulk current threshold crossed |
| topoff_done | input | 1 | Top-off complete |
| chg_en | output | 1 | Charge current enable |
| pwm_run | output | 1 | Converter run (low = stopped) |
| phase | output | 2 | Charge phase code |
| chg_fault | output | 1 | Charge fault flag |
| chg_timer | output | TW | Charge timer count |

## Verification
A wrong internal state shows on the phase code or the timer by the first edge after the stimulus that exposes it. For example, a missed pause leaves the timer one count high after a hot cycle. A cycle that fails to start shows phase 00 one edge after the qualifiers line up. A missed timeout shows the fault still low one edge after the timer reads the limit. The start qualifiers are swept over every combination from idle, and each reset cause is applied in turn mid-cycle. The timer limit is hit separately in precharge, bulk and top-off to tell a fault apart from a clean end.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_BULK = 3'd2,
      ST_TOP  = 3'd3,
      ST_DONE = 3'd4,
      ST_TFLT = 3'd5
   } chg_state_e;

   localparam logic [1:0] TH_COLD  = 2'b00;
   localparam logic [1:0] TH_IDEAL = 2'b01;
   localparam logic [1:0] TH_HOT   = 2'b10;
   localparam logic [1:0] TH_OPEN  = 2'b11;

   function automatic logic [1:0] phase_of(input chg_state_e s);
      case (s)
         ST_PRE:  phase_of = 2'b01;
         ST_BULK: phase_of = 2'b10;
         ST_TOP:  phase_of = 2'b11;
         default: phase_of = 2'b00;
      endcase
   endfunction

   function automatic logic is_active(input chg_state_e s);
      is_active = (s == ST_PRE) || (s == ST_BULK) || (s == ST_TOP);
   endfunction

endpackage

// File: rtl/chg_seq_qual.sv
module chg_seq_qual
   import chg_seq_pkg::*;
(
   input  logic       supply_ok,
   input  logic       above_uvlo,
   input  logic       below_rechg,
   input  logic [1:0] therm_code,
   input  logic       temp_chk_en,
   input  logic       shutdown,
   input  logic       por_cmd,
   input  logic       inhibit,
   output logic       force_rst,
   output logic       start_ok,
   output logic       hot
);

   logic temp_ok;
   logic therm_open;

   always_comb begin
      therm_open = temp_chk_en && (therm_code == TH_OPEN);
      hot        = temp_chk_en && (therm_code == TH_HOT);
      temp_ok    = !temp_chk_en || (therm_code == TH_COLD) || (therm_code == TH_IDEAL);
      force_rst  = !supply_ok || !above_uvlo || shutdown || por_cmd || therm_open;
      start_ok   = !force_rst && below_rechg && temp_ok && !inhibit;
   end

endmodule

// File: rtl/chg_seq_timer.sv
module chg_seq_timer #(
   parameter int TW      = 8,
   parameter int T_LIMIT = 20
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          run,
   output logic [TW-1:0] count,
   output logic          at_limit
);

   localparam logic [TW-1:0] LIM = TW'(T_LIMIT);

   if (TW < 2) begin : g_bad_width
      $error("chg_seq_timer: TW must be at least 2");
   end
   if (T_LIMIT < 1 || T_LIMIT > (2 ** TW) - 1) begin : g_bad_limit
      $error("chg_seq_timer: T_LIMIT must fit in TW bits and be nonzero");
   end

   assign at_limit = (count == LIM);

   always_ff @(posedge clk) begin
      if (rst || clr)
         count <= '0;
      else if (run && !at_limit)
         count <= count + 1'b1;
   end

   a_r9_limit_bound: assert property (@(posedge clk) disable iff (rst)
      count <= LIM);

endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
   import chg_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       force_rst,
   input  logic       start_ok,
   input  logic       pre_done,
   input  logic       bulk_done,
   input  logic       topoff_done,
   input  logic       at_limit,
   output chg_state_e state
);

   chg_state_e nxt;

   always_comb begin
      nxt = state;
      if (force_rst)
         nxt = ST_IDLE;
      else begin
         case (state)
            ST_IDLE, ST_DONE: if (start_ok) nxt = ST_PRE;
            ST_PRE: begin
               if (at_limit)      nxt = ST_TFLT;
               else if (pre_done) nxt = ST_BULK;
            end
            ST_BULK: begin
               if (at_limit)       nxt = ST_TFLT;
               else if (bulk_done) nxt = ST_TOP;
            end
            ST_TOP: if (at_limit || topoff_done) nxt = ST_DONE;
            ST_TFLT: nxt = ST_TFLT;
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

   a_r3_no_skip_bulk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PRE && !force_rst) |=> (state != ST_TOP));

   a_r9_fault_sticks: assert property (@(posedge clk) disable iff (rst)
      (state == ST_TFLT && !force_rst) |=> (state == ST_TFLT));

endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
   import chg_seq_pkg::*;
#(
   parameter int TW      = 8,
   parameter int T_LIMIT = 20
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          supply_ok,
   input  logic          above_uvlo,
   input  logic          below_rechg,
   input  logic          bat_ov,
   input  logic [1:0]    therm_code,
   input  logic          temp_chk_en,
   input  logic          shutdown,
   input  logic          por_cmd,
   input  logic          inhibit,
   input  logic          pre_done,
   input  logic          bulk_done,
   input  logic          topoff_done,
   output logic          chg_en,
   output logic          pwm_run,
   output logic [1:0]    phase,
   output logic          chg_fault,
   output logic [TW-1:0] chg_timer
);

   logic       force_rst, start_ok, hot, at_limit;
   logic       active, idle_like, tmr_clr, tmr_run;
   chg_state_e state;

   chg_seq_qual u_qual (
      .supply_ok   (supply_ok),
      .above_uvlo  (above_uvlo),
      .below_rechg (below_rechg),
      .therm_code  (therm_code),
      .temp_chk_en (temp_chk_en),
      .shutdown    (shutdown),
      .por_cmd     (por_cmd),
      .inhibit     (inhibit),
      .force_rst   (force_rst),
      .start_ok    (start_ok),
      .hot         (hot)
   );

   chg_seq_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .force_rst   (force_rst),
      .start_ok    (start_ok),
      .pre_done    (pre_done),
      .bulk_done   (bulk_done),
      .topoff_done (topoff_done),
      .at_limit    (at_limit),
      .state       (state)
   );

   always_comb begin
      active    = is_active(state);
      idle_like = (state == ST_IDLE) || (state == ST_DONE);
      tmr_clr   = force_rst || (idle_like && start_ok);
      tmr_run   = active && !hot;
   end

   chg_seq_timer #(.TW(TW), .T_LIMIT(T_LIMIT)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .clr      (tmr_clr),
      .run      (tmr_run),
      .count    (chg_timer),
      .at_limit (at_limit)
   );

   always_comb begin
      phase     = phase_of(state);
      chg_en    = active && !force_rst && !hot && !inhibit;
      pwm_run   = chg_en && !bat_ov;
      chg_fault = (state == ST_TFLT) || (active && hot && !force_rst);
   end

   a_r7_force_clears: assert property (@(posedge clk) disable iff (rst)
      force_rst |=> (phase == 2'b00 && chg_timer == '0 && !chg_fault));

   a_r6_hot_holds_timer: assert property (@(posedge clk) disable iff (rst)
      (active && hot && !force_rst) |=> (chg_timer == $past(chg_timer)));

   a_r8_timer_runs: assert property (@(posedge clk) disable iff (rst)
      (active && !hot && !force_rst && !at_limit) |=>
         (chg_timer == TW'($past(chg_timer) + 1'b1)));

   a_r5_ov_stops_pwm: assert property (@(posedge clk) disable iff (rst)
      bat_ov |-> !pwm_run);

   a_r9_fault_no_current: assert property (@(posedge clk) disable iff (rst)
      chg_fault |-> !chg_en);

endmodule

// File: tb/chg_seq_ctrl_tb.sv
module chg_seq_ctrl_tb;

   localparam int TW = 5;
   localparam int L  = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic supply_ok, above_uvlo, below_rechg, bat_ov, temp_chk_en;
   logic shutdown, por_cmd, inhibit, pre_done, bulk_done, topoff_done;
   logic [1:0] therm_code;
   logic chg_en, pwm_run, chg_fault;
   logic [1:0] phase;
   logic [TW-1:0] chg_timer;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   chg_seq_ctrl #(.TW(TW), .T_LIMIT(L)) u_dut (
      .clk(clk), .rst(rst), .supply_ok(supply_ok), .above_uvlo(above_uvlo),
      .below_rechg(below_rechg), .bat_ov(bat_ov), .therm_code(therm_code),
      .temp_chk_en(temp_chk_en), .shutdown(shutdown), .por_cmd(por_cmd),
      .inhibit(inhibit), .pre_done(pre_done), .bulk_done(bulk_done),
      .topoff_done(topoff_done), .chg_en(chg_en), .pwm_run(pwm_run),
      .phase(phase), .chg_fault(chg_fault), .chg_timer(chg_timer)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic defaults();
      supply_ok = 1; above_uvlo = 1; below_rechg = 0; bat_ov = 0;
      therm_code = 2'b01; temp_chk_en = 1; shutdown = 0; por_cmd = 0;
      inhibit = 0; pre_done = 0; bulk_done = 0; topoff_done = 0;
   endtask

   task automatic to_idle();
      defaults(); shutdown = 1; tick(); shutdown = 0; #1;
   endtask

   task automatic go_pre();
      below_rechg = 1; tick(); below_rechg = 0; #1;
      chk("R2 enter precharge", phase, 1);
      chk("R2 timer cleared", chg_timer, 0);
   endtask

   task automatic pulse_pre();
      pre_done = 1; tick(); pre_done = 0; #1;
   endtask

   task automatic pulse_bulk();
      bulk_done = 1; tick(); bulk_done = 0; #1;
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int t;
      defaults();
      rst = 1;
      tick(); tick();
      chk("R1 phase in reset", phase, 0);
      chk("R1 chg_en in reset", chg_en, 0);
      rst = 0; tick(); #1;
      chk("R1 phase", phase, 0);
      chk("R1 chg_en", chg_en, 0);
      chk("R1 pwm_run", pwm_run, 0);
      chk("R1 fault", chg_fault, 0);
      chk("R1 timer", chg_timer, 0);

      // R2 / R10: sweep start qualifiers from idle
      for (int v = 0; v < 128; v++) begin
         bit frc, st;
         supply_ok   = v[0];
         above_uvlo  = v[1];
         below_rechg = v[2];
         therm_code  = v[4:3];
         temp_chk_en = v[5];
         inhibit     = v[6];
         frc = !v[0] || !v[1] || (v[5] && v[4:3] == 2'b11);
         st  = !frc && v[2] && (!v[5] || v[4:3] < 2) && !v[6];
         tick(); #1;
         chk(v[5] ? "R2 start sweep" : "R10 start sweep, thermistor unchecked",
             phase, st ? 1 : 0);
         to_idle();
         chk("R7 sweep return", phase, 0);
      end

      // R3 / R4: full clean cycle
      to_idle();
      go_pre();
      tick();
      chk("R3 precharge timer counts", chg_timer, 1);
      chk("R3 chg_en in precharge", chg_en, 1);
      pulse_pre();
      chk("R3 bulk phase", phase, 2);
      chk("R3 bulk timer", chg_timer, 2);
      pulse_bulk();
      chk("R3 top-off phase", phase, 3);
      topoff_done = 1; tick(); topoff_done = 0; #1;
      chk("R3 done phase", phase, 0);
      chk("R4 no fault after clean end", chg_fault, 0);
      chk("R4 current off when done", chg_en, 0);
      tick(); tick(); tick();
      chk("R4 no restart above threshold", phase, 0);
      below_rechg = 1; tick(); below_rechg = 0; #1;
      chk("R4 auto-recharge restarts", phase, 1);
      chk("R4 restart clears timer", chg_timer, 0);
      pulse_pre();
      chk("R3 bulk after restart", phase, 2);

      // R5 overvoltage
      bat_ov = 1; #1;
      chk("R5 pwm stopped", pwm_run, 0);
      chk("R5 current stays", chg_en, 1);
      chk("R5 no fault", chg_fault, 0);
      t = chg_timer;
      tick();
      chk("R5 timer runs", chg_timer, t + 1);
      chk("R5 phase held", phase, 2);
      bat_ov = 0; #1;
      chk("R5 pwm resumes", pwm_run, 1);

      // R6 hot
      therm_code = 2'b10; #1;
      chk("R6 current off", chg_en, 0);
      chk("R6 pwm off", pwm_run, 0);
      chk("R6 fault set", chg_fault, 1);
      t = chg_timer;
      tick(); tick();
      chk("R6 timer paused", chg_timer, t);
      chk("R6 phase held", phase, 2);
      therm_code = 2'b01; #1;
      chk("R6 fault clears", chg_fault, 0);
      chk("R6 current back", chg_en, 1);
      tick();
      chk("R6 timer resumes", chg_timer, t + 1);

      // R8 inhibit
      inhibit = 1; #1;
      chk("R8 current off", chg_en, 0);
      chk("R8 pwm off", pwm_run, 0);
      t = chg_timer;
      tick();
      chk("R8 timer keeps running", chg_timer, t + 1);
      chk("R8 phase held", phase, 2);
      inhibit = 0; #1;
      chk("R8 current resumes", chg_en, 1);

      // R10 thermistor ignored when unchecked
      temp_chk_en = 0; therm_code = 2'b11; #1;
      chk("R10 open ignored, current", chg_en, 1);
      tick();
      chk("R10 open ignored, phase", phase, 2);
      therm_code = 2'b10; #1;
      chk("R10 hot ignored, fault", chg_fault, 0);
      t = chg_timer;
      tick();
      chk("R10 hot ignored, timer", chg_timer, t + 1);
      therm_code = 2'b01; temp_chk_en = 1;

      // R7 each forced reset cause
      for (int c = 0; c < 5; c++) begin
         to_idle();
         go_pre();
         tick();
         case (c)
            0: supply_ok = 0;
            1: above_uvlo = 0;
            2: shutdown = 1;
            3: por_cmd = 1;
            default: therm_code = 2'b11;
         endcase
         #1;
         chk("R7 current drops at once", chg_en, 0);
         tick();
         chk("R7 phase to off", phase, 0);
         chk("R7 timer cleared", chg_timer, 0);
         defaults(); tick();
         chk("R7 stays off", phase, 0);
      end

      // R9 timeout in precharge
      to_idle();
      go_pre();
      for (int k = 1; k <= L; k++) begin
         tick();
         chk("R9 precharge timer step", chg_timer, k);
      end
      chk("R9 no fault at limit cycle", chg_fault, 0);
      tick();
      chk("R9 precharge timeout fault", chg_fault, 1);
      chk("R9 phase off on fault", phase, 0);
      chk("R9 current off on fault", chg_en, 0);
      below_rechg = 1; tick(); tick(); below_rechg = 0; #1;
      chk("R9 fault latched, no restart", chg_fault, 1);
      chk("R9 phase stays off", phase, 0);
      to_idle();
      chk("R9 fault cleared by reset cause", chg_fault, 0);

      // R9 timeout in bulk
      go_pre();
      pulse_pre();
      while (chg_timer < L) tick();
      chk("R9 still bulk at limit", phase, 2);
      tick();
      chk("R9 bulk timeout fault", chg_fault, 1);

      // R9 timeout in top-off ends cleanly
      to_idle();
      go_pre();
      pulse_pre();
      pulse_bulk();
      while (chg_timer < L) tick();
      chk("R9 still top-off at limit", phase, 3);
      tick();
      chk("R9 top-off timeout phase", phase, 0);
      chk("R9 top-off timeout no fault", chg_fault, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule